// File: doc/BRIEF.md
# Multi-Channel DMA Register Front-End

This block is the register file that a processor sees for a sixteen-channel DMA controller. It decodes 32-bit reads and writes from two address windows. The main 4 KB window holds channels 0 to 14 and two global registers. A second, small window holds only the last channel. For each channel the block keeps a control/status word, a descriptor-pointer register and a scratch debug word. It also returns the engine's current descriptor fields, which software can read but not write.

The transfer engines sit outside the block. They report progress through per-channel set and clear strobes and through flat buses that carry their descriptor fields. The block gives the engines a one-cycle start pulse when software arms a channel. It drives one interrupt line per channel, and it exposes a global per-channel enable vector.

Top module: `dmac_regfile`

## Requirements
- R1: After a synchronous reset, every channel's status, descriptor pointer and debug word read 0. The global enable reads 0xFFFF, the interrupt vector reads 0, and no interrupt line is asserted.
- R2: In the main window, an address below 0xF00 selects channel addr[11:8] and the register addr[7:0]. Any address in the second window selects the last channel. The per-channel offsets are: 0x00 status, 0x04 descriptor pointer, 0x20 debug, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride and 0x1C next pointer.
- R3: The six descriptor offsets from 0x08 to 0x1C return the engine's field inputs for the selected channel. A write to any of them changes nothing and raises the error pulse.
- R4: A status write replaces the status bits under mask 0x30FF0001 with the written data. All other stored bits are kept. Bits 31 and 30 always read back as 0, and writing 1 to bit 30 has no other effect.
- R5: Writing 1 to status bit 1 clears the END flag. Writing 1 to status bit 2 clears the INT flag, drops that channel's interrupt line and clears its bit in the global interrupt vector.
- R6: Writing 1 to status bit 31 clears the channel's whole status word and its descriptor pointer. The debug word is kept.
- R7: The start output pulses for exactly one cycle, one cycle after a status write that takes ACTIVE (bit 0) from 0 to 1. Writing 1 when ACTIVE is already 1 gives no pulse.
- R8: The engine strobes set END (bit 1), INT (bit 2) or PAUSED (bit 4), or clear ACTIVE, on the edge where they are sampled. They win over a bus write to the same bit in the same cycle. When the clear wins, no start pulse is given.
- R9: Main-window offset 0xFE0 reads the per-channel interrupt vector (bit n = channel n), and writes to it are ignored without error. Offset 0xFF0 is the global enable: only its low 16 bits are stored, and the value also drives the enable output.
- R10: Read data and the error flag are registered and appear one cycle after the request. An access that is not 32 bits wide, or that targets an unknown offset, reads 0, changes no state and raises the error flag for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_aux | input | 1 | 1 selects the last-channel window, 0 the main window |
| bus_we | input | 1 | 1 write, 0 read |
| bus_word | input | 1 | 1 when the access is 32 bits wide |
| bus_addr | input | 12 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an invalid access |
| eng_end_set | input | 16 | Per-channel END set strobe |
| eng_int_set | input | 16 | Per-channel INT set strobe |
| eng_pause_set | input | 16 | Per-channel PAUSED set strobe |
| eng_active_clr | input | 16 | Per-channel ACTIVE clear strobe |
| eng_info | input | 512 | Info field of each channel, 32 bits per channel |
| eng_src | input | 512 | Source address of each channel |
| eng_dst | input | 512 | Destination address of each channel |
| eng_len | input | 512 | Remaining length of each channel |
| eng_stride | input | 512 | Stride field of each channel |
| eng_next | input | 512 | Next-descriptor pointer of each channel |
| ch_start | output | 16 | One-cycle start pulse per channel |
| ch_irq | output | 16 | Interrupt line per channel |
| ch_enable | output | 16 | Global enable vector |

## Verification
The bench uses the default parameters: sixteen channels of 32-bit registers and a 12-bit window offset. These defaults match the fixed address layout. They let the bench reach both edges of the decode: channel 14 at the top of the main window, the last channel through the second window, and the global offsets just above the channel area. Because every channel exists, the bench can drive each engine strobe against a bus write to the same channel in the same cycle. It can also check that operations on one channel leave its neighbours untouched in the interrupt vector.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_W = 32;

  // status bit positions
  localparam int ST_ACTIVE = 0;
  localparam int ST_END    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_PAUSED = 4;
  localparam int ST_ABORT  = 30;
  localparam int ST_CLR    = 31;
  localparam logic [REG_W-1:0] ST_WMASK = 32'h30FF_0001;

  // per-channel offsets
  localparam logic [7:0] OFS_CS   = 8'h00;
  localparam logic [7:0] OFS_PTR  = 8'h04;
  localparam logic [7:0] OFS_INFO = 8'h08;
  localparam logic [7:0] OFS_SRC  = 8'h0C;
  localparam logic [7:0] OFS_DST  = 8'h10;
  localparam logic [7:0] OFS_LEN  = 8'h14;
  localparam logic [7:0] OFS_STR  = 8'h18;
  localparam logic [7:0] OFS_NXT  = 8'h1C;
  localparam logic [7:0] OFS_DBG  = 8'h20;

  // global offsets in the main window
  localparam logic [11:0] GLB_BASE  = 12'hF00;
  localparam logic [11:0] GLB_ISTAT = 12'hFE0;
  localparam logic [11:0] GLB_EN    = 12'hFF0;

  typedef enum logic [3:0] {
    SEL_CS, SEL_PTR, SEL_INFO, SEL_SRC, SEL_DST, SEL_LEN,
    SEL_STR, SEL_NXT, SEL_DBG, SEL_ISTAT, SEL_EN, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic          req,
  input  logic          aux,
  input  logic          we,
  input  logic          word,
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel,
  output logic [CW-1:0] ch,
  output logic          bad
);
  logic [7:0] ofs;
  logic       chan_hit;

  always_comb begin
    sel      = SEL_NONE;
    ch       = '0;
    ofs      = addr[7:0];
    chan_hit = 1'b0;
    if (req && word) begin
      if (aux) begin
        ch       = CW'(NCH - 1);
        chan_hit = 1'b1;
      end else if (addr < GLB_BASE) begin
        ch       = CW'(addr[11:8]);
        chan_hit = (int'(addr[11:8]) < NCH - 1);
      end else if (addr == GLB_ISTAT) begin
        sel = SEL_ISTAT;
      end else if (addr == GLB_EN) begin
        sel = SEL_EN;
      end
      if (chan_hit) begin
        case (ofs)
          OFS_CS:   sel = SEL_CS;
          OFS_PTR:  sel = SEL_PTR;
          OFS_INFO: sel = SEL_INFO;
          OFS_SRC:  sel = SEL_SRC;
          OFS_DST:  sel = SEL_DST;
          OFS_LEN:  sel = SEL_LEN;
          OFS_STR:  sel = SEL_STR;
          OFS_NXT:  sel = SEL_NXT;
          OFS_DBG:  sel = SEL_DBG;
          default:  sel = SEL_NONE;
        endcase
      end
    end
  end

  // invalid: nothing decoded, or a write to a read-only mirror
  always_comb begin
    bad = 1'b0;
    if (req) begin
      if (sel == SEL_NONE) bad = 1'b1;
      else if (we && (sel inside {SEL_INFO, SEL_SRC, SEL_DST, SEL_LEN, SEL_STR, SEL_NXT}))
        bad = 1'b1;
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cs,
  input  logic             wr_ptr,
  input  logic             wr_dbg,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_end,
  input  logic             set_int,
  input  logic             set_pause,
  input  logic             clr_active,
  output logic [REG_W-1:0] cs,
  output logic [REG_W-1:0] ptr,
  output logic [REG_W-1:0] dbg,
  output logic             start
);
  logic [REG_W-1:0] cs_nx;

  always_comb begin
    cs_nx = cs;
    if (wr_cs) begin
      if (wdata[ST_CLR]) cs_nx = '0;
      if (wdata[ST_END]) cs_nx[ST_END] = 1'b0;
      if (wdata[ST_INT]) cs_nx[ST_INT] = 1'b0;
      cs_nx = (cs_nx & ~ST_WMASK) | (wdata & ST_WMASK);
    end
    if (set_end)    cs_nx[ST_END]    = 1'b1;
    if (set_int)    cs_nx[ST_INT]    = 1'b1;
    if (set_pause)  cs_nx[ST_PAUSED] = 1'b1;
    if (clr_active) cs_nx[ST_ACTIVE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs    <= '0;
      ptr   <= '0;
      dbg   <= '0;
      start <= 1'b0;
    end else begin
      cs    <= cs_nx;
      start <= wr_cs && !cs[ST_ACTIVE] && cs_nx[ST_ACTIVE];
      if (wr_cs && wdata[ST_CLR]) ptr <= '0;
      else if (wr_ptr)            ptr <= wdata;
      if (wr_dbg) dbg <= wdata;
    end
  end

  // R7: a start pulse always coincides with a fresh ACTIVE edge
  a_r7_start_on_edge: assert property (@(posedge clk) disable iff (rst)
    start && $past(!rst) |-> cs[ST_ACTIVE] && !$past(cs[ST_ACTIVE]));

  // R8: engine END set wins over a same-cycle clear
  a_r8_end_set_wins: assert property (@(posedge clk) disable iff (rst)
    $past(set_end) && $past(!rst) |-> cs[ST_END]);

  // R8: engine ACTIVE clear wins over a same-cycle arm
  a_r8_active_clr_wins: assert property (@(posedge clk) disable iff (rst)
    $past(clr_active) && $past(!rst) |-> !cs[ST_ACTIVE] && !start);

  // R6: channel reset empties the descriptor pointer
  a_r6_reset_clears_ptr: assert property (@(posedge clk) disable iff (rst)
    $past(wr_cs && wdata[ST_CLR] && !rst) |-> ptr == '0);

  // R4: the self-clearing bits never stick
  a_r4_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> !cs[ST_CLR] && !cs[ST_ABORT]);
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 12,
  parameter int DW  = REG_W,
  localparam int CW = $clog2(NCH),
  localparam int FW = NCH * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_aux,
  input  logic          bus_we,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  input  logic [NCH-1:0] eng_end_set,
  input  logic [NCH-1:0] eng_int_set,
  input  logic [NCH-1:0] eng_pause_set,
  input  logic [NCH-1:0] eng_active_clr,
  input  logic [FW-1:0]  eng_info,
  input  logic [FW-1:0]  eng_src,
  input  logic [FW-1:0]  eng_dst,
  input  logic [FW-1:0]  eng_len,
  input  logic [FW-1:0]  eng_stride,
  input  logic [FW-1:0]  eng_next,
  output logic [NCH-1:0] ch_start,
  output logic [NCH-1:0] ch_irq,
  output logic [NCH-1:0] ch_enable
);
  reg_sel_e      sel;
  logic [CW-1:0] ch;
  logic          bad;
  logic [DW-1:0] cs_a  [NCH];
  logic [DW-1:0] ptr_a [NCH];
  logic [DW-1:0] dbg_a [NCH];
  logic [DW-1:0] rd_mux;
  logic          wr_ok;

  dmac_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .req(bus_req), .aux(bus_aux), .we(bus_we), .word(bus_word),
    .addr(bus_addr), .sel(sel), .ch(ch), .bad(bad)
  );

  assign wr_ok = bus_req && bus_we && !bad;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_ok && (ch == CW'(i));
    dmac_chan u_chan (
      .clk(clk), .rst(rst),
      .wr_cs(hit && sel == SEL_CS),
      .wr_ptr(hit && sel == SEL_PTR),
      .wr_dbg(hit && sel == SEL_DBG),
      .wdata(bus_wdata),
      .set_end(eng_end_set[i]), .set_int(eng_int_set[i]),
      .set_pause(eng_pause_set[i]), .clr_active(eng_active_clr[i]),
      .cs(cs_a[i]), .ptr(ptr_a[i]), .dbg(dbg_a[i]), .start(ch_start[i])
    );
    assign ch_irq[i] = cs_a[i][ST_INT];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CS:    rd_mux = cs_a[ch];
      SEL_PTR:   rd_mux = ptr_a[ch];
      SEL_DBG:   rd_mux = dbg_a[ch];
      SEL_INFO:  rd_mux = eng_info[ch*DW +: DW];
      SEL_SRC:   rd_mux = eng_src[ch*DW +: DW];
      SEL_DST:   rd_mux = eng_dst[ch*DW +: DW];
      SEL_LEN:   rd_mux = eng_len[ch*DW +: DW];
      SEL_STR:   rd_mux = eng_stride[ch*DW +: DW];
      SEL_NXT:   rd_mux = eng_next[ch*DW +: DW];
      SEL_ISTAT: rd_mux = DW'(ch_irq);
      SEL_EN:    rd_mux = DW'(ch_enable);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      ch_enable <= '1;
    end else begin
      bus_err   <= bad;
      bus_rdata <= (bus_req && !bus_we && !bad) ? rd_mux : '0;
      if (wr_ok && sel == SEL_EN) ch_enable <= bus_wdata[NCH-1:0];
    end
  end

  // R9: enable comes out of reset all ones
  a_r9_enable_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ch_enable == '1);

  // R10: an error pulse follows a request
  a_r10_err_needs_req: assert property (@(posedge clk) disable iff (rst)
    bus_err && $past(!rst) |-> $past(bus_req));

  // R10: an invalid access returns zero data
  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_rdata == '0);
endmodule

// File: tb/dmac_regfile_test.sv
module dmac_regfile_test;
  localparam int NCH = 16;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_req = 0, b_aux = 0, b_we = 0, b_word = 1;
  logic [11:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] rdata;
  logic err;
  logic [NCH-1:0] e_end = '0, e_int = '0, e_pause = '0, e_aclr = '0;
  logic [NCH*DW-1:0] f_info, f_src, f_dst, f_len, f_str, f_nxt;
  logic [NCH-1:0] start, irq, en;

  logic [DW-1:0]  s_rd;
  logic           s_err;
  logic [NCH-1:0] s_start, s_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmac_regfile uut (
    .clk(clk), .rst(rst), .bus_req(b_req), .bus_aux(b_aux), .bus_we(b_we),
    .bus_word(b_word), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(rdata), .bus_err(err),
    .eng_end_set(e_end), .eng_int_set(e_int), .eng_pause_set(e_pause),
    .eng_active_clr(e_aclr), .eng_info(f_info), .eng_src(f_src),
    .eng_dst(f_dst), .eng_len(f_len), .eng_stride(f_str), .eng_next(f_nxt),
    .ch_start(start), .ch_irq(irq), .ch_enable(en)
  );

  initial begin
    for (int c = 0; c < NCH; c++) begin
      f_info[c*DW +: DW] = 32'h1000_0000 + c;
      f_src [c*DW +: DW] = 32'h2000_0000 + c;
      f_dst [c*DW +: DW] = 32'h3000_0000 + c;
      f_len [c*DW +: DW] = 32'h4000_0000 + c;
      f_str [c*DW +: DW] = 32'h5000_0000 + c;
      f_nxt [c*DW +: DW] = 32'h6000_0000 + c;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one bus/engine cycle; outputs sampled at the following negedge
  task automatic cyc(input logic req, input logic aux, input logic we, input logic word,
                     input logic [11:0] a, input logic [DW-1:0] d,
                     input logic [NCH-1:0] ee, input logic [NCH-1:0] ei,
                     input logic [NCH-1:0] ep, input logic [NCH-1:0] ea);
    @(negedge clk);
    b_req = req; b_aux = aux; b_we = we; b_word = word; b_addr = a; b_wdata = d;
    e_end = ee; e_int = ei; e_pause = ep; e_aclr = ea;
    @(negedge clk);
    s_rd = rdata; s_err = err; s_start = start; s_irq = irq;
    b_req = 0; b_we = 0; b_word = 1;
    e_end = '0; e_int = '0; e_pause = '0; e_aclr = '0;
  endtask

  task automatic wr(input logic aux, input logic [11:0] a, input logic [DW-1:0] d);
    cyc(1, aux, 1, 1, a, d, '0, '0, '0, '0);
  endtask

  task automatic rd(input logic aux, input logic [11:0] a);
    cyc(1, aux, 0, 1, a, '0, '0, '0, '0, '0);
  endtask

  task automatic t_reset;
    rd(0, 12'h000); chk("R1 cs ch0", s_rd, 0);
    rd(0, 12'h704); chk("R1 ptr ch7", s_rd, 0);
    rd(0, 12'hFF0); chk("R1 enable", s_rd, 32'hFFFF);
    rd(0, 12'hFE0); chk("R1 irq vector", s_rd, 0);
    chk("R1 irq lines", 32'(irq), 0);
    chk("R1 enable out", 32'(en), 32'hFFFF);
  endtask

  task automatic t_decode;
    wr(0, 12'h304, 32'hA5A5_0040);
    wr(0, 12'h320, 32'h1234_5678);
    wr(0, 12'hE04, 32'h0E0E_0E00);
    wr(1, 12'h004, 32'h1500_0000);
    rd(0, 12'h304); chk("R2 ptr ch3", s_rd, 32'hA5A5_0040);
    rd(0, 12'h320); chk("R2 dbg ch3", s_rd, 32'h1234_5678);
    rd(0, 12'hE04); chk("R2 ptr ch14", s_rd, 32'h0E0E_0E00);
    rd(1, 12'h004); chk("R2 ptr ch15 aux", s_rd, 32'h1500_0000);
    rd(0, 12'h404); chk("R2 ptr ch4 untouched", s_rd, 0);
  endtask

  task automatic t_mirror;
    rd(0, 12'h50C); chk("R3 src ch5", s_rd, 32'h2000_0005);
    rd(0, 12'h010); chk("R3 dst ch0", s_rd, 32'h3000_0000);
    rd(1, 12'h008); chk("R3 info ch15", s_rd, 32'h1000_000F);
    rd(0, 12'hA14); chk("R3 len ch10", s_rd, 32'h4000_000A);
    rd(0, 12'h218); chk("R3 stride ch2", s_rd, 32'h5000_0002);
    rd(0, 12'h11C); chk("R3 next ch1", s_rd, 32'h6000_0001);
    wr(0, 12'h50C, 32'hFFFF_FFFF); chk("R3 ro write err", 32'(s_err), 1);
    rd(0, 12'h50C); chk("R3 src after write", s_rd, 32'h2000_0005);
  endtask

  task automatic t_mask;
    wr(0, 12'h200, 32'h7FFF_FFF8);
    chk("R4 no start", 32'(s_start), 0);
    rd(0, 12'h200); chk("R4 masked cs", s_rd, 32'h30FF_0000);
  endtask

  task automatic t_start;
    wr(0, 12'h200, 32'h1);
    chk("R7 start ch2", 32'(s_start), 32'h4);
    rd(0, 12'h200); chk("R7 cs active", s_rd, 32'h1);
    chk("R7 pulse gone", 32'(s_start), 0);
    wr(0, 12'h200, 32'h1);
    chk("R7 no restart", 32'(s_start), 0);
  endtask

  task automatic t_engine;
    cyc(0, 0, 0, 1, '0, '0, 16'h0004, 16'h0004, 16'h0004, 16'h0004);
    chk("R8 irq ch2", 32'(s_irq), 32'h4);
    rd(0, 12'h200); chk("R8 cs ch2", s_rd, 32'h16);
    rd(0, 12'hFE0); chk("R8 irq vector", s_rd, 32'h4);
    // same-cycle conflict on ch6: arm + clear END vs engine
    cyc(1, 0, 1, 1, 12'h600, 32'h3, 16'h0040, '0, '0, 16'h0040);
    chk("R8 no start when clr wins", 32'(s_start), 0);
    rd(0, 12'h600); chk("R8 end set wins", s_rd, 32'h2);
    cyc(1, 0, 1, 1, 12'h700, 32'h4, '0, 16'h0080, '0, '0);
    chk("R8 int set wins", 32'(s_irq), 32'h84);
  endtask

  task automatic t_w1c;
    wr(0, 12'h200, 32'h2);
    rd(0, 12'h200); chk("R5 end cleared", s_rd, 32'h14);
    chk("R5 irq kept", 32'(s_irq), 32'h84);
    wr(0, 12'h200, 32'h4);
    chk("R5 irq dropped", 32'(s_irq), 32'h80);
    rd(0, 12'h200); chk("R5 int cleared", s_rd, 32'h10);
    rd(0, 12'hFE0); chk("R5 vector bit cleared", s_rd, 32'h80);
  endtask

  task automatic t_chreset;
    cyc(0, 0, 0, 1, '0, '0, '0, '0, 16'h0008, '0);
    wr(0, 12'h300, 32'h1);
    chk("R6 start ch3", 32'(s_start), 32'h8);
    rd(0, 12'h300); chk("R6 cs before", s_rd, 32'h11);
    wr(0, 12'h300, 32'h8000_0000);
    rd(0, 12'h300); chk("R6 cs cleared", s_rd, 0);
    rd(0, 12'h304); chk("R6 ptr cleared", s_rd, 0);
    rd(0, 12'h320); chk("R6 dbg kept", s_rd, 32'h1234_5678);
  endtask

  task automatic t_global;
    cyc(0, 0, 0, 1, '0, '0, '0, 16'h0200, '0, '0);
    rd(0, 12'hFE0); chk("R9 vector", s_rd, 32'h0280);
    wr(0, 12'hFE0, 32'h0);
    chk("R9 vector write no err", 32'(s_err), 0);
    rd(0, 12'hFE0); chk("R9 vector unchanged", s_rd, 32'h0280);
    wr(0, 12'hFF0, 32'hABCD_1234);
    rd(0, 12'hFF0); chk("R9 enable low bits", s_rd, 32'h1234);
    chk("R9 enable out", 32'(en), 32'h1234);
  endtask

  task automatic t_bad;
    rd(0, 12'h524); chk("R10 unknown read zero", s_rd, 0);
    chk("R10 unknown read err", 32'(s_err), 1);
    rd(0, 12'h000); chk("R10 err one cycle", 32'(s_err), 0);
    wr(0, 12'hF04, 32'hFFFF_FFFF); chk("R10 global hole err", 32'(s_err), 1);
    wr(1, 12'h030, 32'hFFFF_FFFF); chk("R10 aux hole err", 32'(s_err), 1);
    wr(0, 12'h304, 32'h0000_BEEF);
    cyc(1, 0, 1, 0, 12'h304, 32'hDEAD_0000, '0, '0, '0, '0);
    chk("R10 narrow write err", 32'(s_err), 1);
    cyc(1, 0, 0, 0, 12'h304, '0, '0, '0, '0, '0);
    chk("R10 narrow read zero", s_rd, 0);
    rd(0, 12'h304); chk("R10 narrow write ignored", s_rd, 32'h0000_BEEF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset;
    t_decode;
    t_mirror;
    t_mask;
    t_start;
    t_engine;
    t_w1c;
    t_chreset;
    t_global;
    t_bad;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule